// File: doc/BRIEF.md
# Programmable Delay Line with Recirculation

This block delays a 10-bit sample stream by a number of clock cycles that can be changed at run time. The path has three parts: an entry register, a variable-depth memory stage, and an exit register. The memory stage is a 1280-word circular store. A single read/write pointer sweeps through it and wraps at the programmed count. The total latency is therefore the programmed count plus two.

A mode input sets where the entry register gets its data. It can take the external input (delay mode) or the exit register (recirculate mode). In recirculate mode the words already stored go round a closed ring, and the ring period is the total latency.

A clock enable freezes every register and the pointer. An output enable sends the data to the output bus, or parks the bus at zero and drops a drive flag, which is the cue for an external tri-state driver.

A small state machine inside the memory stage has two states:
- `ST_BYPASS`: the count is zero and the memory is skipped.
- `ST_SWEEP`: the pointer walks the memory.

It has two transitions, both taken on an enabled length load:
- `GO_SWEEP` from `ST_BYPASS` when the new count is non-zero.
- `GO_BYPASS` from `ST_SWEEP` when the new count is zero.

Top module: `prog_delay_line`

## Requirements
- R1: After reset, `dout` is 0 with `dout_drv` high (when `oe` is 1), and the stored count is 0.
- R2: With `loop_mode`=0 and a stored count L, a word sampled from `din` at an enabled edge appears on `dout` right after the L+1-th following enabled edge, for a total latency of L+2 enabled edges.
- R3: On an enabled edge with `len_ld`=1, the 11-bit `len_val` becomes the stored count. On edges with `len_ld`=0 the count is unchanged.
- R4: With a stored count of 0, the memory stage is bypassed and the latency is 2 enabled edges.
- R5: A `len_val` above 1279 is stored as 1279, giving a latency of 1281.
- R6: With `loop_mode`=1, the entry register takes the current `dout` instead of `din`. Stored words repeat on `dout` with period L+2, and `din` has no effect.
- R7: An enabled length load restarts the pointer at zero. Every word sampled at or after the load edge leaves with the new latency.
- R8: While `clk_en`=0, the registers, the memory, the pointer and the stored count all hold, and `len_ld` is ignored.
- R9: With `oe`=0, `dout` reads 0 and `dout_drv` is 0. The stored data is unaffected, and the stream resumes intact when `oe` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; 0 freezes all state |
| loop_mode | input | 1 | 0 = delay mode, 1 = recirculate mode |
| len_ld | input | 1 | Length load strobe |
| len_val | input | 11 | Requested memory-stage count (latency minus 2) |
| din | input | 10 | Input sample |
| oe | input | 1 | Output enable |
| dout | output | 10 | Output sample, 0 while disabled |
| dout_drv | output | 1 | Drive flag for an external tri-state buffer |

## Verification
The bench goes after these corner cases:
- The bypass count of 0. A memory stage that does not skip itself here would add one cycle of latency.
- A count of 1. A pointer that wraps off by one would give a latency of 2 or 4 instead of 3.
- Over-range requests of 1280 and 2047. A design that truncates instead of clamping would store a small count and deliver words about 1280 cycles early.
- Loads issued mid-stream. A design that does not restart the pointer would send new words out at a shifted position.
- Loads attempted while the clock enable is low. A design that lets `len_ld` through would change the latency during the freeze.
- Recirculate mode driven with random input. A design that leaks `din` into the ring would break the L+2 repetition.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    localparam int PDL_DW      = 10;
    localparam int PDL_LW      = 11;
    localparam int PDL_MAX_LEN = 1279;

    typedef enum logic [0:0] {
        ST_BYPASS = 1'b0,
        ST_SWEEP  = 1'b1
    } ram_state_e;

endpackage

// File: rtl/pdl_len_reg.sv
module pdl_len_reg #(
    parameter int LW      = pdl_pkg::PDL_LW,
    parameter int MAX_LEN = pdl_pkg::PDL_MAX_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ld,
    input  logic [LW-1:0] len_in,
    output logic [LW-1:0] len_q,
    output logic [LW-1:0] len_nxt,
    output logic          load_stb
);
    localparam logic [LW-1:0] LimitVal = LW'(MAX_LEN);

    always_comb begin
        len_nxt  = (len_in > LimitVal) ? LimitVal : len_in;
        load_stb = en & ld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (load_stb) begin
            len_q <= len_nxt;
        end
    end

    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(len_q)); // R8

    AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (len_q <= LimitVal)); // R5

endmodule

// File: rtl/pdl_ram_delay.sv
module pdl_ram_delay #(
    parameter int DW    = pdl_pkg::PDL_DW,
    parameter int LW    = pdl_pkg::PDL_LW,
    parameter int DEPTH = pdl_pkg::PDL_MAX_LEN + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          restart,
    input  logic [LW-1:0] len_q,
    input  logic [LW-1:0] len_nxt,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] stage_out
);
    import pdl_pkg::*;

    localparam int PW = $clog2(DEPTH);

    ram_state_e    state, state_nxt;
    logic [PW-1:0] ptr;
    logic [LW-1:0] ptr_ext;
    logic          at_wrap;
    logic [DW-1:0] mem [DEPTH];

    always_comb begin
        ptr_ext = LW'(ptr);
        at_wrap = (ptr_ext == (len_q - LW'(1)));
    end

    // next-state logic: GO_SWEEP / GO_BYPASS on a load
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_BYPASS: if (restart && (len_nxt != '0)) state_nxt = ST_SWEEP;
            ST_SWEEP:  if (restart && (len_nxt == '0)) state_nxt = ST_BYPASS;
            default:   state_nxt = ST_BYPASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BYPASS;
        end else if (en) begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (en) begin
            if (restart) begin
                ptr <= '0;
            end else if (state == ST_SWEEP) begin
                ptr <= at_wrap ? '0 : ptr + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (en && (state == ST_SWEEP)) begin
            mem[ptr] <= wr_data;
        end
    end

    // output selection per state
    always_comb begin
        unique case (state)
            ST_BYPASS: stage_out = wr_data;
            ST_SWEEP:  stage_out = mem[ptr];
            default:   stage_out = wr_data;
        endcase
    end

    AST_PTR_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP) |-> (ptr_ext < len_q)); // R2

    AST_BYPASS_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS) |-> (ptr == '0)); // R4

    AST_STATE_TRACKS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYPASS) == (len_q == '0)); // R4

    AST_RESTART_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ptr == '0)); // R7

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(ptr) && $stable(state))); // R8

endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
    parameter int DW      = pdl_pkg::PDL_DW,
    parameter int LW      = pdl_pkg::PDL_LW,
    parameter int MAX_LEN = pdl_pkg::PDL_MAX_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          loop_mode,
    input  logic          len_ld,
    input  logic [LW-1:0] len_val,
    input  logic [DW-1:0] din,
    input  logic          oe,
    output logic [DW-1:0] dout,
    output logic          dout_drv
);
    localparam int Depth = MAX_LEN + 1;

    logic [LW-1:0] len_q, len_nxt;
    logic          load_stb;
    logic [DW-1:0] in_q, out_q, feed, stage_out;

    pdl_len_reg #(.LW(LW), .MAX_LEN(MAX_LEN)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (clk_en),
        .ld       (len_ld),
        .len_in   (len_val),
        .len_q    (len_q),
        .len_nxt  (len_nxt),
        .load_stb (load_stb)
    );

    pdl_ram_delay #(.DW(DW), .LW(LW), .DEPTH(Depth)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .restart   (load_stb),
        .len_q     (len_q),
        .len_nxt   (len_nxt),
        .wr_data   (in_q),
        .stage_out (stage_out)
    );

    always_comb begin
        feed = loop_mode ? out_q : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            out_q <= '0;
        end else if (clk_en) begin
            in_q  <= feed;
            out_q <= stage_out;
        end
    end

    always_comb begin
        dout     = oe ? out_q : '0;
        dout_drv = oe;
    end

    AST_DELAY_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !loop_mode) |=> (in_q == $past(din))); // R2

    AST_RECIRC_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && loop_mode) |=> (in_q == $past(out_q))); // R6

    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(in_q) && $stable(out_q))); // R8

endmodule

// File: tb/prog_delay_line_bench.sv
module prog_delay_line_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        loop_mode = 1'b0;
    logic        len_ld = 1'b0;
    logic [10:0] len_val = '0;
    logic [9:0]  din = '0;
    logic        oe = 1'b1;
    logic [9:0]  dout;
    logic        dout_drv;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    int         mlen;
    bit         qv[$];
    logic [9:0] qd[$];
    bit         ev;
    logic [9:0] ed;

    always #(CLK_P/2) clk = ~clk;

    prog_delay_line u_prog_delay_line (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .loop_mode(loop_mode),
        .len_ld(len_ld), .len_val(len_val), .din(din), .oe(oe),
        .dout(dout), .dout_drv(dout_drv)
    );

    task automatic chk(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: dout=%0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic step(input logic [9:0] d, input bit ld, input logic [10:0] lv,
                        input bit mode, input bit en, input bit o, input string tag);
        bit         sv;
        logic [9:0] sd;
        @(negedge clk);
        din = d; len_ld = ld; len_val = lv; loop_mode = mode; clk_en = en; oe = o;
        @(posedge clk);
        if (en) begin
            sv = mode ? ev : 1'b1;
            sd = mode ? ed : d;
            if (ld) begin
                mlen = (lv > 11'd1279) ? 1279 : int'(lv);
                qv.delete(); qd.delete();
                for (int i = 0; i <= mlen; i++) begin
                    qv.push_back(1'b0); qd.push_back('0);
                end
            end
            qv.push_back(sv); qd.push_back(sd);
            ev = qv.pop_front();
            ed = qd.pop_front();
        end
        #(CLK_P/4);
        if (!o) chk((dout == '0) && !dout_drv, tag, dout, '0);
        else if (ev) chk((dout == ed) && dout_drv, tag, dout, ed);
    endtask

    task automatic run(input int n, input bit mode, input string tag);
        for (int i = 0; i < n; i++) step(10'($urandom), 1'b0, '0, mode, 1'b1, 1'b1, tag);
    endtask

    task automatic load(input logic [10:0] lv, input string tag);
        step(10'($urandom), 1'b1, lv, 1'b0, 1'b1, 1'b1, tag);
    endtask

    initial begin
        mlen = 0;
        qv.push_back(1'b1); qd.push_back('0);
        ev = 1'b1; ed = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_P/4);
        chk((dout == '0) && dout_drv, "R1", dout, '0);

        run(20, 1'b0, "R4");
        load(11'd5, "R3");
        run(30, 1'b0, "R2");

        // R8: load attempted while frozen must be ignored
        for (int i = 0; i < 6; i++) step(10'($urandom), 1'b1, 11'd9, 1'b0, 1'b0, 1'b1, "R8");
        run(12, 1'b0, "R8");
        for (int i = 0; i < 40; i++) step(10'($urandom), 1'b0, '0, 1'b0, 1'($urandom), 1'b1, "R8");

        // R7: mid-stream reloads
        load(11'd1, "R7");
        run(20, 1'b0, "R7");
        load(11'd0, "R7");
        run(10, 1'b0, "R4");
        load(11'd8, "R7");
        run(25, 1'b0, "R7");

        // R6: fill then recirculate with random din
        load(11'd3, "R3");
        run(10, 1'b0, "R2");
        run(40, 1'b1, "R6");
        for (int i = 0; i < 20; i++) step(10'($urandom), 1'b0, '0, 1'b1, 1'($urandom), 1'b1, "R6");
        run(10, 1'b0, "R2");

        // R9: output disable
        for (int i = 0; i < 8; i++) step(10'($urandom), 1'b0, '0, 1'b0, 1'b1, 1'b0, "R9");
        run(10, 1'b0, "R9");

        // R5: clamp
        load(11'd2047, "R5");
        run(1300, 1'b0, "R5");
        load(11'd1280, "R5");
        run(1290, 1'b0, "R5");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule